// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table held in a memory addressed by 32-bit words. A request brings the virtual address and the byte address of the top-level table. The walker reads the top-level entry and checks its present flag. If that entry is present, it reads the second-level entry and checks that one too. The result is either the translated address or a fault. A fault tells which of the two levels was missing.

The walker handles one request at a time. It accepts a request only while idle. It keeps its answer on the response port until the consumer takes it. The memory port is a read strobe with a word address. Data returns exactly one cycle after the strobe.

The virtual address splits into three fields:
- bits 31:22 index the top-level table;
- bits 21:12 index the second-level table;
- bits 11:0 are the byte offset within a 4 KB page.

Each table entry is 32 bits wide:
- bit 0 is the present flag;
- bits 31:12 hold the frame number;
- every other bit, including the modified flag in bit 1, has no effect on the walk.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `mem_rd_en` are 0.
- R2: The first read goes to word address (`root_base` + 4 × vaddr[31:22]) >> 2. Both `root_base` and the virtual address are the values present when the request is accepted.
- R3: A top-level entry with bit 0 clear ends the walk after that single read. The response then has `resp_fault`=1, `resp_fault_lvl`=0 and `resp_paddr`=0.
- R4: When the top-level entry is present, the second read goes to word address ({entry[31:12], 12'h000} + 4 × vaddr[21:12]) >> 2.
- R5: A second-level entry with bit 0 clear gives a response with `resp_fault`=1, `resp_fault_lvl`=1 and `resp_paddr`=0.
- R6: When both entries are present, the response has `resp_fault`=0 and `resp_paddr` = {leaf[31:12], vaddr[11:0]}. Entry bits 11:1, including the modified flag in bit 1, have no effect.
- R7: While a response is waiting and `resp_ready` is low, the response fields stay unchanged. `req_ready` stays 0 from acceptance until the response is taken. One cycle after the response is taken, `req_ready` is 1 again.
- R8: Every read strobe lasts exactly one cycle. Counting clock edges from the accepting edge, `resp_valid` rises at edge 4 for a two-read walk and at edge 2 for a top-level fault.
- R9: Changes to `req_vaddr` and `root_base` after the accepting edge do not affect any read address or the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and takes a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the top-level table, sampled at acceptance |
| mem_rd_en | output | 1 | Read strobe to the table memory |
| mem_rd_addr | output | 30 | Word address of the read |
| mem_rdata | input | 32 | Read data, valid one cycle after the strobe |
| resp_valid | output | 1 | A response is waiting |
| resp_ready | input | 1 | The consumer takes the response |
| resp_paddr | output | 32 | Translated physical address (0 on fault) |
| resp_fault | output | 1 | The walk hit a missing entry |
| resp_fault_lvl | output | 1 | 0: top level was missing, 1: second level was missing |

## Verification
The bench targets five corner cases, and each one exposes a typical bug:
- **Top-level fault.** A walker that failed to stop here would issue a second read from a garbage frame, and the read count would show it.
- **Second-level fault.** A walker that reported the wrong level would set `resp_fault_lvl` incorrectly.
- **Junk in the ignored entry bits.** Entries with the modified flag and other ignored bits set expose a walker that leaked those bits into the frame or used them as the present test.
- **Extreme indices.** Indices of 0 and 1023 catch field-slicing and index-scaling errors.
- **Inputs changed during a walk.** Scrambling the request inputs after acceptance, while the bench holds off the response, catches a walker that re-samples its inputs or lets its answer drift.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_READ_ROOT = 2'd1,
    ST_READ_LEAF = 2'd2,
    ST_DONE      = 2'd3
  } walk_state_e;

  localparam logic LVL_ROOT = 1'b0;
  localparam logic LVL_LEAF = 1'b1;

  localparam int PRESENT_BIT = 0;

endpackage

// File: rtl/pgwalk_pte_dec.sv
module pgwalk_pte_dec #(
  parameter int PTE_W = 32,
  parameter int OFF_W = 12
) (
  input  logic [PTE_W-1:0]       pte_i,
  output logic [PTE_W-OFF_W-1:0] frame_o,
  output logic                   present_o
);
  import pgwalk_pkg::*;

  logic unused_ctl;

  assign frame_o    = pte_i[PTE_W-1:OFF_W];
  assign present_o  = pte_i[PRESENT_BIT];
  // control bits other than present play no part in the walk
  assign unused_ctl = ^pte_i[OFF_W-1:PRESENT_BIT+1];

endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic                   sel_leaf,
  input  logic [VA_W-1:0]        base_i,
  input  logic [VA_W-1:0]        vaddr_i,
  input  logic [PTE_W-OFF_W-1:0] frame_i,
  output logic [VA_W-3:0]        waddr_o
);
  localparam int LEAF_LO = OFF_W;
  localparam int ROOT_LO = OFF_W + IDX_W;

  logic [VA_W-1:0] root_byte;
  logic [VA_W-1:0] leaf_byte;
  logic [VA_W-1:0] sel_byte;
  logic [1:0]      unused_lo;

  always_comb begin
    root_byte = base_i + (VA_W'(vaddr_i[ROOT_LO +: IDX_W]) << 2);
    leaf_byte = VA_W'({frame_i, {OFF_W{1'b0}}})
              + (VA_W'(vaddr_i[LEAF_LO +: IDX_W]) << 2);
    sel_byte  = sel_leaf ? leaf_byte : root_byte;
  end

  assign waddr_o   = sel_byte[VA_W-1:2];
  assign unused_lo = sel_byte[1:0];

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [VA_W-1:0]  root_base,
  output logic             mem_rd_en,
  output logic [VA_W-3:0]  mem_rd_addr,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [PTE_W-1:0] resp_paddr,
  output logic             resp_fault,
  output logic             resp_fault_lvl
);
  import pgwalk_pkg::*;

  localparam int MA_W  = VA_W - 2;
  localparam int FRM_W = PTE_W - OFF_W;

  walk_state_e       state_q;
  logic              pend_q;
  logic [VA_W-1:0]   va_q;
  logic              rd_en_q;
  logic [MA_W-1:0]   rd_addr_q;
  logic              rv_q;
  logic [PTE_W-1:0]  pa_q;
  logic              flt_q;
  logic              lvl_q;

  logic [FRM_W-1:0]  ent_frame;
  logic              ent_present;
  logic [VA_W-1:0]   va_src;
  logic [MA_W-1:0]   gen_addr;
  logic              sel_leaf;

  pgwalk_pte_dec #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_dec (
    .pte_i     (mem_rdata),
    .frame_o   (ent_frame),
    .present_o (ent_present)
  );

  assign sel_leaf = (state_q == ST_READ_ROOT);
  assign va_src   = (state_q == ST_IDLE) ? req_vaddr : va_q;

  pgwalk_addr_gen #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) u_agen (
    .sel_leaf (sel_leaf),
    .base_i   (root_base),
    .vaddr_i  (va_src),
    .frame_i  (ent_frame),
    .waddr_o  (gen_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      va_q      <= '0;
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      rv_q      <= 1'b0;
      pa_q      <= '0;
      flt_q     <= 1'b0;
      lvl_q     <= LVL_ROOT;
    end else begin
      rd_en_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q      <= req_vaddr;
            rd_en_q   <= 1'b1;
            rd_addr_q <= gen_addr;
            pend_q    <= 1'b0;
            state_q   <= ST_READ_ROOT;
          end
        end
        ST_READ_ROOT: begin
          if (!pend_q) begin
            pend_q <= 1'b1;
          end else if (!ent_present) begin
            rv_q    <= 1'b1;
            flt_q   <= 1'b1;
            lvl_q   <= LVL_ROOT;
            pa_q    <= '0;
            state_q <= ST_DONE;
          end else begin
            rd_en_q   <= 1'b1;
            rd_addr_q <= gen_addr;
            pend_q    <= 1'b0;
            state_q   <= ST_READ_LEAF;
          end
        end
        ST_READ_LEAF: begin
          if (!pend_q) begin
            pend_q <= 1'b1;
          end else begin
            rv_q    <= 1'b1;
            state_q <= ST_DONE;
            if (!ent_present) begin
              flt_q <= 1'b1;
              lvl_q <= LVL_LEAF;
              pa_q  <= '0;
            end else begin
              flt_q <= 1'b0;
              lvl_q <= LVL_ROOT;
              pa_q  <= {ent_frame, va_q[OFF_W-1:0]};
            end
          end
        end
        default: begin
          if (resp_ready) begin
            rv_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign mem_rd_en      = rd_en_q;
  assign mem_rd_addr    = rd_addr_q;
  assign resp_valid     = rv_q;
  assign resp_paddr     = pa_q;
  assign resp_fault     = flt_q;
  assign resp_fault_lvl = lvl_q;

  AST_ACCEPT_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_rd_en);                              // R2
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);                                            // R8
  AST_NO_READ_WHILE_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !mem_rd_en);                                           // R3
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));                   // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !req_ready);                                           // R7
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr)
      && $stable(resp_fault) && $stable(resp_fault_lvl)));                // R7

endmodule

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/1ps
module sim_pgwalk_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr, root_base;
  logic        mem_rd_en;
  logic [29:0] mem_rd_addr;
  logic [31:0] mem_rdata;
  logic        resp_valid, resp_ready;
  logic [31:0] resp_paddr;
  logic        resp_fault, resp_fault_lvl;

  int n_chk  = 0;
  int n_fail = 0;
  int rd_count = 0;
  logic [31:0] rd_log [2];
  logic [31:0] mem_model [int unsigned];

  always #2.5 clk = ~clk;

  pgwalk_top u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_base(root_base), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .resp_fault_lvl(resp_fault_lvl)
  );

  function automatic logic [31:0] mget(input logic [31:0] w);
    return mem_model.exists(w) ? mem_model[w] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mget({2'b00, mem_rd_addr});
      if (rd_count < 2) rd_log[rd_count] <= {2'b00, mem_rd_addr};
      rd_count <= rd_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the walk, following the requirements
  task automatic ref_walk(input logic [31:0] va, input logic [31:0] base,
                          output logic flt, output logic lvl, output logic [31:0] pa,
                          output int nrd, output logic [31:0] w0, output logic [31:0] w1);
    logic [31:0] e0, e1, b0, b1;
    b0 = base + {20'h0, va[31:22], 2'b00};
    w0 = b0 >> 2;
    e0 = mget(w0);
    w1 = 32'h0; pa = 32'h0; lvl = 1'b0; flt = 1'b0;
    if (!e0[0]) begin
      flt = 1'b1; nrd = 1;
    end else begin
      b1 = {e0[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      w1 = b1 >> 2;
      e1 = mget(w1);
      nrd = 2;
      if (!e1[0]) begin
        flt = 1'b1; lvl = 1'b1;
      end else begin
        pa = {e1[31:12], va[11:0]};
      end
    end
  endtask

  task automatic setup(input logic [31:0] va, input logic [31:0] base,
                       input logic [31:0] root_e, input logic [31:0] leaf_e);
    logic [31:0] w;
    mem_model.delete();
    w = (base + {20'h0, va[31:22], 2'b00}) >> 2;
    mem_model[w] = root_e;
    w = ({root_e[31:12], 12'h000} + {20'h0, va[21:12], 2'b00}) >> 2;
    mem_model[w] = leaf_e;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input int hold);
    logic ef, el; logic [31:0] epa, w0, w1, hp; int enr, lat;
    logic hf, hl;
    ref_walk(va, base, ef, el, epa, enr, w0, w1);
    @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready before request", {31'h0, req_ready}, 32'h1);
    rd_count = 0;
    req_valid = 1'b1; req_vaddr = va; root_base = base;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom; root_base = $urandom;   // R9 scramble after acceptance
    lat = 0;
    while (!resp_valid && lat < 20) begin
      chk(req_ready === 1'b0, "R7 busy not ready", {31'h0, req_ready}, 32'h0);
      @(negedge clk);
      lat++;
    end
    chk(lat == (enr == 1 ? 2 : 4), "R8 response latency", lat, (enr == 1 ? 2 : 4));
    chk(rd_count == enr, "R3 read count", rd_count, enr);
    chk(rd_log[0] == w0, "R2 R9 first read address", rd_log[0], w0);
    if (enr == 2) chk(rd_log[1] == w1, "R4 second read address", rd_log[1], w1);
    chk(resp_fault == ef, "R3 R5 fault flag", {31'h0, resp_fault}, {31'h0, ef});
    if (ef) chk(resp_fault_lvl == el, (el ? "R5 fault level" : "R3 fault level"),
                {31'h0, resp_fault_lvl}, {31'h0, el});
    chk(resp_paddr == epa, (ef ? "R3 R5 paddr zero" : "R6 R9 physical address"), resp_paddr, epa);
    hp = resp_paddr; hf = resp_fault; hl = resp_fault_lvl;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(resp_valid && resp_paddr == hp && resp_fault == hf && resp_fault_lvl == hl && !req_ready,
          "R7 response held", resp_paddr, hp);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(!resp_valid && req_ready, "R7 released to idle", {30'h0, resp_valid, req_ready}, 32'h1);
    chk(rd_count == enr, "R8 no extra reads", rd_count, enr);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] va, base, re, le;
    void'($urandom(32'h5EED1234));
    rst = 1'b1; req_valid = 1'b0; resp_ready = 1'b0;
    req_vaddr = '0; root_base = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 reset ready", {31'h0, req_ready}, 32'h1);
    chk(resp_valid === 1'b0, "R1 reset resp_valid", {31'h0, resp_valid}, 32'h0);
    chk(mem_rd_en === 1'b0, "R1 reset rd_en", {31'h0, mem_rd_en}, 32'h0);
    rst = 1'b0;

    // R3: root missing, junk elsewhere in the entry
    va = 32'hFFC0_1ABC; base = 32'h0001_0000;
    setup(va, base, 32'hABCDE_FFE, 32'h12345_001);
    walk(va, base, 2);
    // R5: leaf missing
    va = 32'h0000_0123; base = 32'h0002_0000;
    setup(va, base, 32'h00050_003, 32'h77777_FFE);
    walk(va, base, 1);
    // R6: modified flag and junk bits set, maximum indices
    va = 32'hFFFF_FFFF; base = 32'h0003_0000;
    setup(va, base, 32'h00060_FFF, 32'hBEEF1_FFF);
    walk(va, base, 3);
    // R6: zero indices, minimal entry
    va = 32'h0000_0000; base = 32'h0000_1000;
    setup(va, base, 32'h00400_001, 32'h00001_001);
    walk(va, base, 0);

    for (int t = 0; t < 150; t++) begin
      va   = $urandom;
      base = $urandom & 32'hFFFF_FFFC;
      re   = $urandom; re[0] = ($urandom % 4) != 0;
      le   = $urandom; le[0] = ($urandom % 4) != 0;
      setup(va, base, re, le);
      walk(va, base, $urandom % 4);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule